// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

The block multiplies two 32-bit operands over many clock cycles, using one 32-bit adder and one 64-bit product register. A pulse on `start` captures the operands. The multiplicand goes into its own register. The multiplier goes into the low half of the product register, and the high half is cleared. Each step then looks at the lowest product bit. When that bit is 1, the step adds the multiplicand into the high half. The step then shifts the whole register right by one place, and the carry out of the add enters at the top. This frees one multiplier bit per step and fills the product from the top.

With `signed_mode` high, both operands are taken as two's complement values. The block multiplies their magnitudes and negates the 64-bit result at the end when the operand signs differ. The result appears together with a one-cycle `done` pulse. It stays on `product` until the next accepted start.

The control is a three-state machine:
- **IDLE** waits for a start. IDLE→RUN is taken on `start`, and the operands are loaded on that edge.
- **RUN** performs one add-and-shift per clock. RUN→RUN is taken while the step count is below 31. RUN→FIX is taken on the 32nd step.
- **FIX** applies the sign correction and raises `done` for one cycle. FIX→IDLE is always taken.

`busy` is high in RUN and FIX.

Top module: `seq_mult`

## Requirements
- R1: After reset is released and before any start, `product` is 0 and both `busy` and `done` are 0.
- R2: A `start` seen at a clock edge while `busy` is 0 captures both operands and the mode. `busy` is 1 from the next cycle on.
- R3: A `start` seen while `busy` is 1 is ignored. The running operation finishes with the product of the operands captured at its own start.
- R4: In unsigned mode (`signed_mode`=0), the final `product` equals the 64-bit unsigned product of the two operands.
- R5: The carry out of every 32-bit add is kept. The unsigned product of 0xFFFFFFFF by 0xFFFFFFFF is 0xFFFFFFFE00000001.
- R6: In signed mode (`signed_mode`=1), the final `product` equals the 64-bit two's complement product. It is negated exactly when the operand signs differ.
- R7: Signed mode handles the most negative operand 0x80000000. For example, 0x80000000 times 0x80000000 gives 0x4000000000000000, and 0x80000000 times 1 gives 0xFFFFFFFF80000000.
- R8: `done` is a single-cycle pulse. From the `done` cycle until the next accepted start, `product` holds its value.
- R9: `busy` stays high for exactly 33 cycles after an accepted start: 32 step cycles and one correction cycle. `done` rises in the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| signed_mode | input | 1 | 1: operands are two's complement; 0: unsigned |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier |
| product | output | 64 | Product register; final result valid from `done` on |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The assertions assume that `start`, `signed_mode` and the operands hold known values at every edge after reset. They make no assumption that `start` stays low while `busy` is high. That case is legal, and the assertions are written so that it leaves them intact. The stimulus changes inputs shortly after a rising edge so that each value is settled well before the next edge. It raises `start` both in idle and in the middle of a run, and it covers the zero, one, all-ones and most-negative operands in both modes.

// File: rtl/mult_pkg.sv
package mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mult_state_t;
endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    mult_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_FIX;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIX);
            if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        fix  = (state_q == ST_FIX);
        busy = (state_q != ST_IDLE);
        done = done_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                          // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                               // R2
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != LAST) |=> step);                        // R9
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               fix,
    input  logic               signed_mode,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    logic             neg_q;

    logic             a_neg, b_neg;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic [WIDTH:0]   sum;
    logic [PW-1:0]    shifted;

    always_comb begin
        a_neg   = signed_mode & mcand[WIDTH-1];
        b_neg   = signed_mode & mplier[WIDTH-1];
        a_mag   = a_neg ? (~mcand + 1'b1) : mcand;
        b_mag   = b_neg ? (~mplier + 1'b1) : mplier;
        sum     = {1'b0, prod_q[PW-1:WIDTH]} +
                  {1'b0, (prod_q[0] ? mcand_q : {WIDTH{1'b0}})};
        shifted = {sum, prod_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
            neg_q   <= 1'b0;
        end else if (load) begin
            mcand_q <= a_mag;
            prod_q  <= {{WIDTH{1'b0}}, b_mag};
            neg_q   <= a_neg ^ b_neg;
        end else if (step) begin
            prod_q  <= shifted;
        end else if (fix) begin
            if (neg_q) prod_q <= ~prod_q + 1'b1;
        end
    end

    assign product = prod_q;

    AST_LOAD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prod_q[PW-1:WIDTH] == '0));                     // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step && !fix) |=> $stable(prod_q));            // R8
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               signed_mode,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product,
    output logic               busy,
    output logic               done
);
    logic load, step, fix;

    mult_ctrl #(.STEPS(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    mult_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .fix         (fix),
        .signed_mode (signed_mode),
        .mcand       (mcand),
        .mplier      (mplier),
        .product     (product)
    );
endmodule

// File: tb/sim_seq_mult.sv
`timescale 1ns/1ps
module sim_seq_mult;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          signed_mode = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic [2*W-1:0] product;
    logic          busy, done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    seq_mult #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .mcand(mcand), .mplier(mplier), .product(product),
        .busy(busy), .done(done)
    );

    // reference model state
    int            m_rem = 0;
    bit            m_done = 0;
    bit            m_known = 1;
    logic [2*W-1:0] m_exp = '0;
    logic [2*W-1:0] m_prod = '0;
    string         cur_tag = "R1";
    string         m_tag = "R1";

    function automatic logic [2*W-1:0] calc(logic [W-1:0] a, logic [W-1:0] b, bit s);
        longint sa, sb;
        logic [2*W-1:0] ua, ub;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        ua = {32'b0, a};
        ub = {32'b0, b};
        return ua * ub;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = 0; m_done = 0; m_known = 1; m_prod = '0;
        end else begin
            m_done = 0;
            if (m_rem == 0) begin
                if (start) begin
                    m_rem   = W + 1;
                    m_exp   = calc(mcand, mplier, signed_mode);
                    m_known = 0;
                    m_tag   = cur_tag;
                end
            end else begin
                m_rem--;
                if (m_rem == 0) begin
                    m_done  = 1;
                    m_prod  = m_exp;
                    m_known = 1;
                end
            end
        end
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (m_rem > 0), "R9 busy", 64'(busy), 64'(m_rem > 0));
            check(done == m_done, "R8 done", 64'(done), 64'(m_done));
            if (m_known)
                check(product === m_prod, m_tag, product, m_prod);
        end
    end

    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit s, string tag);
        @(posedge clk); #2;
        cur_tag = tag; mcand = a; mplier = b; signed_mode = s; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        mcand = $urandom; mplier = $urandom; signed_mode = ~s;
        repeat (W + 2) @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(product == '0 && !busy && !done, "R1 reset", product, 64'd0);

        run_op(32'd17, 32'd19, 1'b0, "R4 small unsigned");
        run_op(32'd0, 32'hFFFFFFFF, 1'b0, "R4 zero");
        run_op(32'd1, 32'hDEADBEEF, 1'b0, "R4 one");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R5 carry all ones");
        run_op(32'h80000000, 32'h80000000, 1'b0, "R5 top bits unsigned");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R6 minus one squared");
        run_op(32'hFFFFFFF9, 32'd6, 1'b1, "R6 signs differ");
        run_op(32'd5, 32'hFFFFFFFD, 1'b1, "R6 signs differ b");
        run_op(32'h80000000, 32'h80000000, 1'b1, "R7 min squared");
        run_op(32'h80000000, 32'd1, 1'b1, "R7 min times one");
        run_op(32'h80000000, 32'hFFFFFFFF, 1'b1, "R7 min times minus one");
        run_op(32'd0, 32'h80000000, 1'b1, "R6 zero signed");

        // R3: a second start during a run is ignored
        @(posedge clk); #2;
        cur_tag = "R3 start while busy";
        mcand = 32'h12345678; mplier = 32'h9ABCDEF0; signed_mode = 1'b0; start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
        repeat (5) @(posedge clk);
        #2; mcand = 32'h1; mplier = 32'h1; signed_mode = 1'b1; start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
        repeat (W) @(posedge clk);
        #2;
        check(product == calc(32'h12345678, 32'h9ABCDEF0, 1'b0), "R3 result",
              product, calc(32'h12345678, 32'h9ABCDEF0, 1'b0));

        // R8: product holds while idle
        repeat (6) @(posedge clk);
        #2;
        check(product == calc(32'h12345678, 32'h9ABCDEF0, 1'b0), "R8 hold",
              product, calc(32'h12345678, 32'h9ABCDEF0, 1'b0));

        for (int i = 0; i < 25; i++) begin
            run_op($urandom, $urandom, 1'b0, "R4 random unsigned");
            run_op($urandom, $urandom, 1'b1, "R6 random signed");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule